// File: doc/BRIEF.md
# Serial Configuration Write Sequencer

This block sits on the host side of a three-wire serial configuration port: a serial clock, a data line and a latch strobe. When it sees a start pulse, it sends a fixed series of 32-bit register writes to a clock-generation device. Each word carries a 28-bit data field in its upper bits and a 4-bit register address in its lowest four bits. The block shifts each word out most significant bit first. It then raises the latch strobe so that the device commits the word to the addressed register.

The data fields come from one of two places, picked by a select input. The first is a wide parallel configuration bus that holds one 28-bit field for each programmable register. The second is a built-in default table that the block computes. The order of the writes is fixed. A reset write to register 0 comes first. Registers 0 to 7 follow, then 11, then 14, and register 15 always comes last. An enable mask can drop any of registers 0 to 7 and 11, but registers 14 and 15 are always sent.

The serial clock is derived from the system clock through a programmable half-period divider. The block drives `busy` for the length of the run and pulses `done` when it finishes.

Top module: `cfg_seq`

## Requirements
- R1: The first word latched after a start is 32'h8000_0000: bit 31 (the reset flag) is set, every other data bit is 0, and the address is 0.
- R2: A later write of register 0 carries bit 31 cleared to 0. Its bits 30:4 are taken from the selected source.
- R3: After the reset write, the enabled registers are written in the order 0,1,...,7,11,14,15. Mask bit i (0 to 7) enables register i and mask bit 8 enables register 11; a register whose bit is 0 is skipped.
- R4: Registers 14 and 15 are written on every run, and 15 is the last word. With an all-zero mask, exactly three words are sent: 0 (reset), 14 and 15.
- R5: Each word is {data[27:0], addr[3:0]}, sent bit 31 first. `ser_data` changes only while `ser_clk` is low and holds steady through each high phase.
- R6: Within a word, `ser_clk` has a period of 2*(div_half+1) system clocks with a 50% duty cycle. It is low whenever the block is idle.
- R7: `ser_le` is low while bits shift. It rises after the 32nd falling edge of the serial clock, stays high for 2*(div_half+1) system clocks with `ser_clk` low, and is low when idle.
- R8: With `src_sel`=0, the data for register slot k is `cfg_words[28k+27:28k]`, where k=0..7 are registers 0..7, k=8 is register 11, k=9 is register 14 and k=10 is register 15. With `src_sel`=1, the data for register a is {a[3:0], 24'h3C5A00 + a}.
- R9: `busy` is high from the cycle after an accepted start until the cycle after the last latch. In that cycle `busy` falls and `done` is high for exactly one cycle.
- R10: A start pulse while `busy` is high has no effect: the run in progress finishes with its original words and a single `done`.
- R11: `enable_mask`, `src_sel` and `div_half` are sampled when a start is accepted. Changing them during a run changes neither the words nor the timing of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; accepted only while idle |
| src_sel | input | 1 | 0: parallel configuration bus, 1: built-in table |
| enable_mask | input | 9 | Bits 0-7 enable registers 0-7, bit 8 enables register 11 |
| div_half | input | DIV_W (8) | Serial clock half-period in system clocks, minus one |
| cfg_words | input | NUM_TBL*DATA_W (308) | Eleven 28-bit data fields, slot k at bits 28k+27:28k |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_data | output | 1 | Serial data, MSB first |
| ser_le | output | 1 | Latch strobe; rising edge commits a word |
| busy | output | 1 | High during a run |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
A wrong slot counter or wrong next-slot logic shows up at the first latch strobe after the fault, as a wrong address or a missing or repeated word. A fault in the word builder shows as a wrong data field within the 32 serial clocks of the affected word. A divider or phase fault shows as a wrong serial period or strobe width at the next edge. A latch-state fault shows as `done` missing, lasting too long or arriving early. The bench decodes the serial lines with its own receiver and compares every word against a list that it builds from the mask, the source and the divider.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    localparam int DATA_W   = 28;
    localparam int ADDR_W   = 4;
    localparam int WORD_W   = DATA_W + ADDR_W;
    localparam int NUM_SLOT = 12;
    localparam int SLOT_W   = $clog2(NUM_SLOT);
    localparam int NUM_TBL  = NUM_SLOT - 1;
    localparam int MASK_W   = 9;
    localparam int RST_BIT  = DATA_W - 1;
    localparam int BIT_W    = $clog2(WORD_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_LATCH
    } seq_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] addr;
    } cfg_word_t;

    // Slot 0 is the reset write; slots 1..8 are registers 0..7;
    // slot 9 is register 11; slot 10 is 14; slot 11 is 15.
    function automatic logic [ADDR_W-1:0] slot_addr(input logic [SLOT_W-1:0] s);
        logic [ADDR_W-1:0] a;
        case (s)
            4'd0:    a = 4'd0;
            4'd9:    a = 4'd11;
            4'd10:   a = 4'd14;
            4'd11:   a = 4'd15;
            default: a = ADDR_W'(s - 4'd1);
        endcase
        return a;
    endfunction

    function automatic logic [SLOT_W-1:0] slot_tbl_idx(input logic [SLOT_W-1:0] s);
        return (s == '0) ? '0 : s - 4'd1;
    endfunction

    function automatic logic [DATA_W-1:0] tbl_default(input logic [ADDR_W-1:0] a);
        logic [23:0] low;
        low = 24'h3C5A00 + {20'd0, a};
        return {a, low};
    endfunction

endpackage

// File: rtl/cfg_tick.sv
module cfg_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)      cnt <= '0;
        else if (cnt == div)  cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == div);

    // R6
    tick_count_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> (!run || cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/cfg_step.sv
module cfg_step
    import cfg_seq_pkg::*;
(
    input  logic [SLOT_W-1:0] cur,
    input  logic [MASK_W-1:0] mask,
    output logic [SLOT_W-1:0] nxt,
    output logic              last
);
    logic [NUM_SLOT-1:0] slot_on;

    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_on
        if (g == 0 || g >= NUM_SLOT - 2) begin : g_fixed
            assign slot_on[g] = 1'b1;
        end else begin : g_mask
            assign slot_on[g] = mask[g-1];
        end
    end

    always_comb begin
        nxt = SLOT_W'(NUM_SLOT - 1);
        for (int s = NUM_SLOT - 1; s >= 1; s--) begin
            if (SLOT_W'(s) > cur && slot_on[s]) nxt = SLOT_W'(s);
        end
    end

    assign last = (cur == SLOT_W'(NUM_SLOT - 1));
endmodule

// File: rtl/cfg_word.sv
module cfg_word
    import cfg_seq_pkg::*;
(
    input  logic [SLOT_W-1:0]         slot,
    input  logic                      src_sel,
    input  logic [NUM_TBL*DATA_W-1:0] cfg_words,
    output logic [WORD_W-1:0]         word
);
    logic [ADDR_W-1:0] a;
    logic [SLOT_W-1:0] idx;
    logic [DATA_W-1:0] src, data;
    cfg_word_t         w;

    always_comb begin
        a   = slot_addr(slot);
        idx = slot_tbl_idx(slot);
        if (src_sel) src = tbl_default(a);
        else         src = cfg_words[int'(idx)*DATA_W +: DATA_W];
        if (slot == '0) begin
            data = '0;
            data[RST_BIT] = 1'b1;
        end else begin
            data = src;
            if (a == '0) data[RST_BIT] = 1'b0;
        end
        w.data = data;
        w.addr = a;
        word   = w;
    end
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
    import cfg_seq_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      src_sel,
    input  logic [MASK_W-1:0]         enable_mask,
    input  logic [DIV_W-1:0]          div_half,
    input  logic [NUM_TBL*DATA_W-1:0] cfg_words,
    output logic                      ser_clk,
    output logic                      ser_data,
    output logic                      ser_le,
    output logic                      busy,
    output logic                      done
);
    seq_state_e        st;
    logic [SLOT_W-1:0] slot, nxt, ld_slot;
    logic              last, tick, phase, lcnt, ld_src;
    logic [BIT_W-1:0]  bit_idx;
    logic [WORD_W-1:0] word_q, ld_word;
    logic [MASK_W-1:0] mask_q;
    logic              src_q;
    logic [DIV_W-1:0]  div_q;
    logic              leave;

    assign busy    = (st != ST_IDLE);
    assign ld_slot = (st == ST_IDLE) ? '0 : nxt;
    assign ld_src  = (st == ST_IDLE) ? src_sel : src_q;
    assign leave   = (st == ST_LATCH) && tick && lcnt;

    cfg_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .run(busy), .div(div_q), .tick(tick)
    );

    cfg_step u_step (
        .cur(slot), .mask(mask_q), .nxt(nxt), .last(last)
    );

    cfg_word u_word (
        .slot(ld_slot), .src_sel(ld_src), .cfg_words(cfg_words), .word(ld_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            slot     <= '0;
            bit_idx  <= '0;
            phase    <= 1'b0;
            lcnt     <= 1'b0;
            word_q   <= '0;
            mask_q   <= '0;
            src_q    <= 1'b0;
            div_q    <= '0;
            ser_clk  <= 1'b0;
            ser_data <= 1'b0;
            ser_le   <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        mask_q   <= enable_mask;
                        src_q    <= src_sel;
                        div_q    <= div_half;
                        slot     <= '0;
                        word_q   <= ld_word;
                        ser_data <= ld_word[WORD_W-1];
                        bit_idx  <= BIT_W'(WORD_W - 1);
                        phase    <= 1'b0;
                        st       <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!phase) begin
                            ser_clk <= 1'b1;
                            phase   <= 1'b1;
                        end else begin
                            ser_clk <= 1'b0;
                            phase   <= 1'b0;
                            if (bit_idx == '0) begin
                                ser_le <= 1'b1;
                                lcnt   <= 1'b0;
                                st     <= ST_LATCH;
                            end else begin
                                bit_idx  <= bit_idx - 1'b1;
                                ser_data <= word_q[bit_idx - 1'b1];
                            end
                        end
                    end
                end
                ST_LATCH: begin
                    if (tick) begin
                        if (!lcnt) begin
                            lcnt <= 1'b1;
                        end else begin
                            lcnt   <= 1'b0;
                            ser_le <= 1'b0;
                            if (last) begin
                                st       <= ST_IDLE;
                                done     <= 1'b1;
                                ser_data <= 1'b0;
                            end else begin
                                slot     <= nxt;
                                word_q   <= ld_word;
                                ser_data <= ld_word[WORD_W-1];
                                bit_idx  <= BIT_W'(WORD_W - 1);
                                st       <= ST_SHIFT;
                            end
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R7
    le_clk_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ser_le && ser_clk));

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> $stable(ser_data));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ser_clk && !ser_le));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_end_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R3
    order_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (slot >= $past(slot)));

    // R4
    r14_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (leave && slot == 4'd9) |=> (slot == 4'd10));

    // R10
    restart_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && st != ST_LATCH) |=> (slot == $past(slot) && busy));
endmodule

// File: tb/sim_cfg_seq.sv
module sim_cfg_seq;
    localparam int DIV_W = 8;
    localparam int DW = 28;
    localparam int NT = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic src_sel = 1'b0;
    logic [8:0] enable_mask = '0;
    logic [DIV_W-1:0] div_half = '0;
    logic [NT*DW-1:0] cfg_words;
    logic ser_clk, ser_data, ser_le, busy, done;

    always #2 clk = ~clk;

    cfg_seq #(.DIV_W(DIV_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .src_sel(src_sel),
        .enable_mask(enable_mask), .div_half(div_half), .cfg_words(cfg_words),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .busy(busy), .done(done)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Serial receiver and timing monitor.
    logic [31:0] cap [16];
    int ncap = 0, nbits = 0, ndone = 0;
    int per_err = 0, hold_err = 0, le_err = 0, ovl_err = 0, fmt_err = 0, done_err = 0;
    int exp_per = 2;
    longint cyc = 0, last_rise = 0, le_start = 0;
    logic [31:0] sh = '0;
    logic p_clk = 0, p_le = 0, p_done = 0, p_busy = 0, p_dat = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (ser_clk && !p_clk) begin
                if (nbits > 0 && (cyc - last_rise) != longint'(exp_per)) per_err++;
                if (ser_data != p_dat) hold_err++;
                last_rise = cyc;
                sh = {sh[30:0], ser_data};
                nbits++;
            end
            if (ser_clk && p_clk && ser_data != p_dat) hold_err++;
            if (ser_le && !p_le) begin
                if (nbits != 32) fmt_err++;
                if (ncap < 16) cap[ncap] = sh;
                ncap++;
                nbits = 0;
                le_start = cyc;
            end
            if (!ser_le && p_le && (cyc - le_start) != longint'(exp_per)) le_err++;
            if (ser_le && ser_clk) ovl_err++;
            if (done) begin
                ndone++;
                if (p_done || busy || !p_busy) done_err++;
            end
        end
        p_clk = ser_clk; p_le = ser_le; p_done = done; p_busy = busy; p_dat = ser_data;
    end

    function automatic logic [27:0] pat(input int k);
        return 28'h9234567 ^ (28'h0111111 * 28'(k));
    endfunction

    function automatic int addr_idx(input int a);
        if (a < 8) return a;
        if (a == 11) return 8;
        if (a == 14) return 9;
        return 10;
    endfunction

    function automatic logic [31:0] exp_word(input bit src, input int a, input bit rstw);
        logic [27:0] d;
        if (rstw) return 32'h8000_0000;
        if (src) d = {4'(a), 24'h3C5A00 + 24'(a)};
        else     d = pat(addr_idx(a));
        if (a == 0) d[27] = 1'b0;
        return {d, 4'(a)};
    endfunction

    // Expected sequence built from the requirements.
    logic [31:0] expw [16];
    int nexp;
    task automatic build_exp(input bit src, input logic [8:0] m);
        nexp = 0;
        expw[nexp++] = exp_word(src, 0, 1'b1);
        for (int r = 0; r < 8; r++) if (m[r]) expw[nexp++] = exp_word(src, r, 1'b0);
        if (m[8]) expw[nexp++] = exp_word(src, 11, 1'b0);
        expw[nexp++] = exp_word(src, 14, 1'b0);
        expw[nexp++] = exp_word(src, 15, 1'b0);
    endtask

    task automatic clear_mon();
        ncap = 0; nbits = 0; ndone = 0;
        per_err = 0; hold_err = 0; le_err = 0; ovl_err = 0; fmt_err = 0; done_err = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (ndone > 0) begin ok = 1'b1; break; end
        end
    endtask

    task automatic compare_run(input string tag);
        check(ncap == nexp, "R3/R4 word count", 32'(ncap), 32'(nexp));
        for (int i = 0; i < nexp && i < ncap; i++)
            check(cap[i] === expw[i], (i == 0) ? "R1 reset word" : "R2/R3/R8 word", cap[i], expw[i]);
        check(per_err == 0, "R6 serial period", 32'(per_err), 0);
        check(hold_err == 0 && fmt_err == 0, "R5 data hold/format", 32'(hold_err + fmt_err), 0);
        check(le_err == 0 && ovl_err == 0, "R7 latch strobe", 32'(le_err + ovl_err), 0);
        check(ndone == 1 && done_err == 0, "R9 done pulse", 32'(ndone), 1);
        check(!busy && !ser_clk && !ser_le, "R6 idle low", {29'd0, busy, ser_clk, ser_le}, 0);
        if (n_bad > 0) $display("note: miscompares so far after %s", tag);
    endtask

    // {src, mask[8:0], div[3:0]}
    localparam logic [13:0] VEC [6] = '{
        {1'b0, 9'h1FF, 4'd0},
        {1'b1, 9'h1FF, 4'd1},
        {1'b0, 9'h000, 4'd2},
        {1'b1, 9'h0A5, 4'd0},
        {1'b0, 9'h100, 4'd3},
        {1'b1, 9'h0FE, 4'd1}
    };

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit ok;
        for (int k = 0; k < NT; k++) cfg_words[k*DW +: DW] = pat(k);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(!busy && !done && !ser_clk && !ser_le, "R9 reset state",
              {28'd0, busy, done, ser_clk, ser_le}, 0);

        for (int v = 0; v < 6; v++) begin
            src_sel     = VEC[v][13];
            enable_mask = VEC[v][12:4];
            div_half    = DIV_W'(VEC[v][3:0]);
            exp_per     = 2 * (int'(VEC[v][3:0]) + 1);
            build_exp(VEC[v][13], VEC[v][12:4]);
            clear_mon();
            pulse_start();
            check(busy == 1'b1, "R9 busy after start", {31'd0, busy}, 1);
            wait_done(ok);
            check(ok, "R9 done reached", {31'd0, ok}, 1);
            repeat (3) @(negedge clk);
            compare_run("vector");
        end

        // R10 + R11: restart and setting changes during a run are ignored.
        src_sel = 1'b0; enable_mask = 9'h1FF; div_half = 8'd1; exp_per = 4;
        build_exp(1'b0, 9'h1FF);
        clear_mon();
        pulse_start();
        repeat (150) @(negedge clk);
        enable_mask = 9'h000; src_sel = 1'b1; div_half = 8'd5;
        pulse_start();
        repeat (700) @(negedge clk);
        pulse_start();
        wait_done(ok);
        check(ok, "R10 done reached", {31'd0, ok}, 1);
        repeat (20) @(negedge clk);
        check(ndone == 1, "R10 single done", 32'(ndone), 1);
        check(ncap == nexp, "R11 word count unchanged", 32'(ncap), 32'(nexp));
        for (int i = 0; i < nexp && i < ncap; i++)
            check(cap[i] === expw[i], "R11 word unchanged", cap[i], expw[i]);
        check(per_err == 0, "R11 timing unchanged", 32'(per_err), 0);

        // R4 with all-zero mask: only 0, 14, 15 (table source).
        src_sel = 1'b1; enable_mask = 9'h000; div_half = 8'd0; exp_per = 2;
        build_exp(1'b1, 9'h000);
        clear_mon();
        pulse_start();
        wait_done(ok);
        repeat (3) @(negedge clk);
        check(ncap == 3, "R4 three words", 32'(ncap), 3);
        check(cap[1][3:0] == 4'd14 && cap[2][3:0] == 4'd15, "R4 addresses 14,15",
              {24'd0, cap[1][3:0], cap[2][3:0]}, 32'h0000_00EF);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule